// File: doc/BRIEF.md
# Sixteen-Opcode 16-Bit Processor Core

A single-issue, multi-cycle processor core for a small register machine with 16-bit words, sixteen 16-bit registers and a 4-bit opcode. A state machine steps each instruction through fetch, decode and execute. An extra cycle is added for loads, a stall is added for system calls, and a terminal state is entered on halt. Instruction and data memories are synchronous single-port RAMs outside the core. Read data returns one clock after the address.

Branch targets are taken from a register, not computed from an offset. Jump-and-link adds both a register and a small signed constant to the PC. Immediate operations overwrite their only register operand. A system call raises a trap output carrying a register value and a constant. The core then waits for an acknowledge.

States: ST_FETCH (instruction address out), ST_DECODE (instruction word captured), ST_EXEC (operation performed, memory strobes issued), ST_LOAD (load data written back), ST_TRAP (trap raised, waiting for acknowledge), ST_HALT (terminal). Transitions: FETCH→DECODE and DECODE→EXEC always. EXEC→LOAD on a load, EXEC→TRAP on a system call, EXEC→HALT on a halt, and EXEC→FETCH otherwise. LOAD→FETCH always. TRAP→FETCH when the acknowledge is high. HALT→HALT until reset.

Top module: `hex16_core`

## Requirements
- R1: During reset the instruction address is 0, `halted`, `trap_valid`, `dmem_we` and `dmem_re` are low, and the first instruction is fetched from word 0.
- R2: Register 0 reads as zero, and any write to it is dropped.
- R3: Instruction word: bits [15:12] opcode, [11:8] rd, [7:4] rs1, [3:0] rs2. The three-register opcodes 1=add, 2=subtract, 3=AND, 4=XOR and 5=shift-left compute rd = rs1 op rs2 modulo 2^16. The shift amount is rs2[3:0].
- R4: Opcode 6 shifts rd left by imm[3:0], and opcode 7 adds the zero-extended imm to rd. For both, imm = bits [7:0], and the result is written back into rd.
- R5: Opcode 8 sets PC to rd when rs1 equals rs2. Opcode 9 does the same when rs1 > rs2, compared unsigned. Otherwise the PC becomes PC+1.
- R6: Opcode 10 writes PC+1 into rd and sets PC to PC + rs1 + sign-extended bits [3:0]. The target uses the rs1 value from before the link write, even when rd equals rs1.
- R7: Opcode 12 loads mem[rs1+rs2] into rd, and opcode 13 stores rd to mem[rs1+rs2]. The write and read strobes are never high together.
- R8: Opcode 0 and the unassigned opcode 11 change no register and no memory, and only advance the PC.
- R9: Opcode 14 raises `trap_valid` with `trap_data` = rd value and `trap_code` = bits [7:0]. The core holds these and the PC until `trap_ack` is sampled high, then continues at PC+1.
- R10: Opcode 15 sets `halted`. It stays high until reset, and no further fetch, write or trap happens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| imem_addr | output | 16 | Instruction word address (PC) |
| imem_rdata | input | 16 | Instruction word, one cycle after the address |
| dmem_addr | output | 16 | Data word address |
| dmem_wdata | output | 16 | Store data |
| dmem_we | output | 1 | Store strobe |
| dmem_re | output | 1 | Load strobe |
| dmem_rdata | input | 16 | Load data, one cycle after the strobe |
| trap_valid | output | 1 | System call pending |
| trap_data | output | 16 | Register value passed with the call |
| trap_code | output | 8 | Constant passed with the call |
| trap_ack | input | 1 | System call handled |
| halted | output | 1 | Core has halted |

## Verification
Two collisions are provoked on purpose. The first is a jump-and-link whose link register is also its base register, so the register write and the target computation fall in the same execute cycle. The stored link value and the surviving path show whether the old base value was used. The second is a system call met by an acknowledge that is already high. In that case the trap is raised and released in the same cycle. The bench counts exactly one trap cycle and checks that the program finishes. A second run holds the acknowledge low for several cycles to confirm the stall.

// File: rtl/hex16_pkg.sv
package hex16_pkg;
    localparam int INSTR_W = 16;
    localparam int FIELD_W = 4;

    typedef enum logic [3:0] {
        OP_NOP   = 4'h0,
        OP_ADD   = 4'h1,
        OP_SUB   = 4'h2,
        OP_AND   = 4'h3,
        OP_XOR   = 4'h4,
        OP_SLL   = 4'h5,
        OP_SLI   = 4'h6,
        OP_ADDI  = 4'h7,
        OP_BEQ   = 4'h8,
        OP_BGT   = 4'h9,
        OP_JAL   = 4'hA,
        OP_RSVD  = 4'hB,
        OP_LOAD  = 4'hC,
        OP_STORE = 4'hD,
        OP_CALL  = 4'hE,
        OP_HALT  = 4'hF
    } opcode_e;

    typedef enum logic [2:0] {
        ST_FETCH,
        ST_DECODE,
        ST_EXEC,
        ST_LOAD,
        ST_TRAP,
        ST_HALT
    } state_e;
endpackage

// File: rtl/hex16_regfile.sv
module hex16_regfile #(
    parameter int DATA_W  = 16,
    parameter int REG_CNT = 16,
    localparam int AW     = $clog2(REG_CNT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     ra_a,
    input  logic [AW-1:0]     ra_b,
    input  logic [AW-1:0]     ra_c,
    output logic [DATA_W-1:0] rv_a,
    output logic [DATA_W-1:0] rv_b,
    output logic [DATA_W-1:0] rv_c,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [DATA_W-1:0] wr_data
);
    logic [DATA_W-1:0] cells [REG_CNT];

    // entry 0 is hard-wired, so writes to it have nowhere to land
    assign cells[0] = '0;

    for (genvar i = 1; i < REG_CNT; i++) begin : g_cell
        logic [DATA_W-1:0] q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                q <= '0;
            else if (wr_en && wr_addr == AW'(i))
                q <= wr_data;
        end
        assign cells[i] = q;
    end

    assign rv_a = cells[ra_a];
    assign rv_b = cells[ra_b];
    assign rv_c = cells[ra_c];
endmodule

// File: rtl/hex16_alu.sv
module hex16_alu
    import hex16_pkg::*;
#(
    parameter int DATA_W = 16,
    localparam int SH_W  = $clog2(DATA_W)
) (
    input  opcode_e           op,
    input  logic [DATA_W-1:0] x,
    input  logic [DATA_W-1:0] y,
    output logic [DATA_W-1:0] res
);
    always_comb begin
        case (op)
            OP_ADD, OP_ADDI: res = x + y;
            OP_SUB:          res = x - y;
            OP_AND:          res = x & y;
            OP_XOR:          res = x ^ y;
            OP_SLL, OP_SLI:  res = x << y[SH_W-1:0];
            default:         res = x;
        endcase
    end
endmodule

// File: rtl/hex16_nextpc.sv
module hex16_nextpc
    import hex16_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  opcode_e           op,
    input  logic [DATA_W-1:0] pc,
    input  logic [DATA_W-1:0] v_d,
    input  logic [DATA_W-1:0] v_s1,
    input  logic [DATA_W-1:0] v_s2,
    input  logic [3:0]        off4,
    output logic [DATA_W-1:0] link,
    output logic [DATA_W-1:0] npc
);
    logic [DATA_W-1:0] off_ext;

    assign off_ext = {{(DATA_W-4){off4[3]}}, off4};
    assign link    = pc + DATA_W'(1);

    always_comb begin
        case (op)
            OP_BEQ:  npc = (v_s1 == v_s2) ? v_d : link;
            OP_BGT:  npc = (v_s1 > v_s2)  ? v_d : link;
            OP_JAL:  npc = pc + v_s1 + off_ext;
            default: npc = link;
        endcase
    end
endmodule

// File: rtl/hex16_core.sv
module hex16_core
    import hex16_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int REG_CNT = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [DATA_W-1:0] imem_addr,
    input  logic [15:0]       imem_rdata,
    output logic [DATA_W-1:0] dmem_addr,
    output logic [DATA_W-1:0] dmem_wdata,
    output logic              dmem_we,
    output logic              dmem_re,
    input  logic [DATA_W-1:0] dmem_rdata,
    output logic              trap_valid,
    output logic [DATA_W-1:0] trap_data,
    output logic [7:0]        trap_code,
    input  logic              trap_ack,
    output logic              halted
);
    localparam int AW = $clog2(REG_CNT);

    state_e               state, state_nx;
    logic [DATA_W-1:0]    pc;
    logic [INSTR_W-1:0]   ir;
    opcode_e              op;
    logic [AW-1:0]        f_d, f_s1, f_s2;
    logic [7:0]           imm8;
    logic [DATA_W-1:0]    v_d, v_s1, v_s2;
    logic [DATA_W-1:0]    alu_x, alu_y, alu_res;
    logic [DATA_W-1:0]    link, npc;
    logic                 wr_en;
    logic [DATA_W-1:0]    wr_data;
    logic                 is_imm;

    // instruction fields
    assign op   = opcode_e'(ir[15:12]);
    assign f_d  = ir[11:8];
    assign f_s1 = ir[7:4];
    assign f_s2 = ir[3:0];
    assign imm8 = ir[7:0];

    hex16_regfile #(.DATA_W(DATA_W), .REG_CNT(REG_CNT)) u_rf (
        .clk    (clk),
        .rst_n  (rst_n),
        .ra_a   (f_d),
        .ra_b   (f_s1),
        .ra_c   (f_s2),
        .rv_a   (v_d),
        .rv_b   (v_s1),
        .rv_c   (v_s2),
        .wr_en  (wr_en),
        .wr_addr(f_d),
        .wr_data(wr_data)
    );

    assign is_imm = (op == OP_SLI) || (op == OP_ADDI);
    assign alu_x  = is_imm ? v_d : v_s1;
    assign alu_y  = is_imm ? {{(DATA_W-8){1'b0}}, imm8} : v_s2;

    hex16_alu #(.DATA_W(DATA_W)) u_alu (
        .op (op),
        .x  (alu_x),
        .y  (alu_y),
        .res(alu_res)
    );

    hex16_nextpc #(.DATA_W(DATA_W)) u_npc (
        .op  (op),
        .pc  (pc),
        .v_d (v_d),
        .v_s1(v_s1),
        .v_s2(v_s2),
        .off4(ir[3:0]),
        .link(link),
        .npc (npc)
    );

    // register write-back
    always_comb begin
        wr_en   = 1'b0;
        wr_data = alu_res;
        if (state == ST_EXEC) begin
            case (op)
                OP_ADD, OP_SUB, OP_AND, OP_XOR, OP_SLL, OP_SLI, OP_ADDI:
                    wr_en = 1'b1;
                OP_JAL: begin
                    wr_en   = 1'b1;
                    wr_data = link;
                end
                default: wr_en = 1'b0;
            endcase
        end else if (state == ST_LOAD) begin
            wr_en   = 1'b1;
            wr_data = dmem_rdata;
        end
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_FETCH:  state_nx = ST_DECODE;
            ST_DECODE: state_nx = ST_EXEC;
            ST_EXEC: begin
                case (op)
                    OP_LOAD: state_nx = ST_LOAD;
                    OP_CALL: state_nx = ST_TRAP;
                    OP_HALT: state_nx = ST_HALT;
                    default: state_nx = ST_FETCH;
                endcase
            end
            ST_LOAD:   state_nx = ST_FETCH;
            ST_TRAP:   state_nx = trap_ack ? ST_FETCH : ST_TRAP;
            ST_HALT:   state_nx = ST_HALT;
            default:   state_nx = ST_HALT;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_FETCH;
        else
            state <= state_nx;
    end

    // program counter and instruction register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc <= '0;
            ir <= '0;
        end else begin
            unique case (state)
                ST_DECODE: ir <= imem_rdata;
                ST_EXEC: begin
                    if (op != OP_LOAD && op != OP_CALL && op != OP_HALT)
                        pc <= npc;
                end
                ST_LOAD: pc <= link;
                ST_TRAP: if (trap_ack) pc <= link;
                default: pc <= pc;
            endcase
        end
    end

    // outputs
    always_comb begin
        imem_addr  = pc;
        dmem_addr  = v_s1 + v_s2;
        dmem_wdata = v_d;
        dmem_we    = 1'b0;
        dmem_re    = 1'b0;
        trap_valid = 1'b0;
        trap_data  = v_d;
        trap_code  = imm8;
        halted     = 1'b0;
        unique case (state)
            ST_EXEC: begin
                dmem_we = (op == OP_STORE);
                dmem_re = (op == OP_LOAD);
            end
            ST_TRAP:  trap_valid = 1'b1;
            ST_HALT:  halted     = 1'b1;
            default:  ;
        endcase
    end
endmodule

// File: rtl/hex16_core_chk.sv
module hex16_core_chk #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [DATA_W-1:0] imem_addr,
    input logic              dmem_we,
    input logic              dmem_re,
    input logic              trap_valid,
    input logic [DATA_W-1:0] trap_data,
    input logic [7:0]        trap_code,
    input logic              trap_ack,
    input logic              halted
);
    assert_strobe_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(dmem_we && dmem_re));

    assert_trap_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_valid && !trap_ack) |=> (trap_valid && $stable(trap_data) && $stable(trap_code)));

    assert_trap_pc_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_valid && !trap_ack) |=> $stable(imem_addr));

    assert_trap_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_valid && trap_ack) |=> !trap_valid);

    assert_halt_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> (halted && $stable(imem_addr)));

    assert_halt_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> (!dmem_we && !dmem_re && !trap_valid));
endmodule

bind hex16_core hex16_core_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .imem_addr (imem_addr),
    .dmem_we   (dmem_we),
    .dmem_re   (dmem_re),
    .trap_valid(trap_valid),
    .trap_data (trap_data),
    .trap_code (trap_code),
    .trap_ack  (trap_ack),
    .halted    (halted)
);

// File: tb/hex16_core_test.sv
module hex16_core_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] imem_addr, imem_rdata;
    logic [15:0] dmem_addr, dmem_wdata, dmem_rdata;
    logic        dmem_we, dmem_re;
    logic        trap_valid, trap_ack, halted;
    logic [15:0] trap_data;
    logic [7:0]  trap_code;
    logic        auto_ack = 1'b1;
    logic        force_ack = 1'b0;

    logic [15:0] imem [256];
    logic [15:0] dmem [256];

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    int trap_cycles = 0;

    always #4 clk = ~clk;

    hex16_core uut (
        .clk(clk), .rst_n(rst_n),
        .imem_addr(imem_addr), .imem_rdata(imem_rdata),
        .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata),
        .dmem_we(dmem_we), .dmem_re(dmem_re), .dmem_rdata(dmem_rdata),
        .trap_valid(trap_valid), .trap_data(trap_data), .trap_code(trap_code),
        .trap_ack(trap_ack), .halted(halted)
    );

    always @(posedge clk) begin
        imem_rdata <= imem[imem_addr[7:0]];
        dmem_rdata <= dmem[dmem_addr[7:0]];
        if (dmem_we) dmem[dmem_addr[7:0]] <= dmem_wdata;
    end

    always @(negedge clk) begin
        cycles++;
        if (trap_valid) trap_cycles++;
        if (auto_ack) trap_ack = trap_valid;
        else trap_ack = force_ack;
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected<150000", cycles);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    function automatic logic [15:0] enc(input int op, input int a, input int b, input int c);
        return {op[3:0], a[3:0], b[3:0], c[3:0]};
    endfunction

    function automatic logic [15:0] enci(input int op, input int a, input int k);
        return {op[3:0], a[3:0], k[7:0]};
    endfunction

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 256; i++) begin
            imem[i] = 16'hFFFF;
            dmem[i] = 16'hDEAD;
        end
    endtask

    task automatic start();
        @(negedge clk);
        rst_n = 1'b0;
        trap_cycles = 0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic run(input string req);
        start();
        for (int i = 0; i < 400 && !halted; i++) @(negedge clk);
        chk(req, {15'd0, halted}, 16'd1);
    endtask

    localparam logic [15:0] VALS [8] = '{16'h0000, 16'h0001, 16'h0002, 16'h7FFF,
                                         16'h8000, 16'hFFFF, 16'h1234, 16'h0011};

    initial begin
        clear_mem();
        // R1 reset state
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk("R1 addr", imem_addr, 16'h0000);
        chk("R1 flags", {12'd0, halted, trap_valid, dmem_we, dmem_re}, 16'h0000);

        // R3 three-register ops sweep
        for (int op = 1; op <= 5; op++) begin
            for (int ia = 0; ia < 8; ia++) begin
                for (int ib = 0; ib < 8; ib++) begin
                    logic [15:0] a, b, e;
                    a = VALS[ia];
                    b = VALS[ib];
                    case (op)
                        1: e = a + b;
                        2: e = a - b;
                        3: e = a & b;
                        4: e = a ^ b;
                        default: e = a << b[3:0];
                    endcase
                    clear_mem();
                    dmem[0] = a;
                    dmem[1] = b;
                    imem[0] = enc(12, 1, 0, 0);
                    imem[1] = enci(7, 3, 1);
                    imem[2] = enc(12, 2, 3, 0);
                    imem[3] = enc(op, 4, 1, 2);
                    imem[4] = enci(7, 3, 1);
                    imem[5] = enc(13, 4, 3, 0);
                    run("R3 done");
                    chk($sformatf("R3 op%0d", op), dmem[2], e);
                end
            end
        end

        // R10 halt stays, no activity
        for (int i = 0; i < 20; i++) @(negedge clk);
        chk("R10 halted", {15'd0, halted}, 16'd1);
        chk("R10 pc", imem_addr, 16'd6);
        chk("R10 quiet", {13'd0, trap_valid, dmem_we, dmem_re}, 16'd0);

        // R4 immediate ops in place
        for (int iv = 0; iv < 8; iv++) begin
            for (int k = 0; k < 20; k++) begin
                for (int op = 6; op <= 7; op++) begin
                    logic [15:0] v, e;
                    int c;
                    v = VALS[iv];
                    c = (k < 16) ? k : (k == 16 ? 8'h13 : (k == 17 ? 8'h7F : (k == 18 ? 8'hFF : 8'h80)));
                    e = (op == 6) ? (v << c[3:0]) : (v + 16'(c));
                    clear_mem();
                    dmem[0] = v;
                    imem[0] = enc(12, 1, 0, 0);
                    imem[1] = enci(op, 1, c);
                    imem[2] = enci(7, 3, 2);
                    imem[3] = enc(13, 1, 3, 0);
                    run("R4 done");
                    chk($sformatf("R4 op%0d c=%0h", op, c), dmem[2], e);
                end
            end
        end

        // R2 register 0 discards writes
        clear_mem();
        imem[0] = enci(7, 0, 5);
        imem[1] = enci(7, 3, 2);
        imem[2] = enc(13, 0, 3, 0);
        imem[3] = enc(1, 0, 3, 3);
        imem[4] = enci(7, 3, 1);
        imem[5] = enc(13, 0, 3, 0);
        run("R2 done");
        chk("R2 after addi", dmem[2], 16'h0000);
        chk("R2 after add", dmem[3], 16'h0000);

        // R5 register-target branches
        for (int op = 8; op <= 9; op++) begin
            for (int ia = 0; ia < 8; ia++) begin
                for (int ib = 0; ib < 8; ib++) begin
                    logic [15:0] a, b;
                    logic taken;
                    a = VALS[ia];
                    b = VALS[ib];
                    taken = (op == 8) ? (a == b) : (a > b);
                    clear_mem();
                    dmem[0] = a;
                    dmem[1] = b;
                    imem[0]  = enci(7, 1, 10);
                    imem[1]  = enc(12, 2, 0, 0);
                    imem[2]  = enci(7, 5, 1);
                    imem[3]  = enc(12, 3, 5, 0);
                    imem[4]  = enc(op, 1, 2, 3);
                    imem[5]  = enci(7, 4, 1);
                    imem[6]  = enci(7, 5, 1);
                    imem[7]  = enc(13, 4, 5, 0);
                    imem[10] = enci(7, 4, 2);
                    imem[11] = enci(7, 5, 1);
                    imem[12] = enc(13, 4, 5, 0);
                    run("R5 done");
                    chk($sformatf("R5 op%0d %h %h", op, a, b), dmem[2], taken ? 16'd2 : 16'd1);
                end
            end
        end

        // R6 jump-and-link, negative offset
        clear_mem();
        imem[0] = enci(7, 1, 4);
        imem[1] = enc(10, 2, 1, 15);
        imem[2] = enci(7, 4, 1);
        imem[4] = enci(7, 5, 2);
        imem[5] = enc(13, 2, 5, 0);
        imem[6] = enci(7, 5, 1);
        imem[7] = enc(13, 4, 5, 0);
        run("R6 done");
        chk("R6 link", dmem[2], 16'd2);
        chk("R6 skipped", dmem[3], 16'd0);

        // R6 link register equals base register
        clear_mem();
        imem[0] = enci(7, 1, 4);
        imem[1] = enc(10, 1, 1, 0);
        imem[5] = enci(7, 5, 2);
        imem[6] = enc(13, 1, 5, 0);
        run("R6 same done");
        chk("R6 same reg", dmem[2], 16'd2);

        // R7 address is sum of two registers
        clear_mem();
        dmem[7] = 16'h1234;
        imem[0] = enci(7, 1, 3);
        imem[1] = enci(7, 2, 4);
        imem[2] = enc(12, 6, 1, 2);
        imem[3] = enc(13, 6, 1, 1);
        run("R7 done");
        chk("R7 load/store", dmem[6], 16'h1234);

        // R8 no-op and unassigned opcode
        clear_mem();
        imem[0] = enci(7, 4, 7);
        imem[1] = 16'h0000;
        imem[2] = 16'hB4FF;
        imem[3] = enci(7, 3, 2);
        imem[4] = enc(13, 4, 3, 0);
        run("R8 done");
        chk("R8 reg kept", dmem[2], 16'd7);
        chk("R8 no trap", trap_cycles[15:0], 16'd0);

        // R9 trap with delayed acknowledge
        clear_mem();
        imem[0] = enci(7, 1, 8'h33);
        imem[1] = enci(14, 1, 8'h5A);
        imem[2] = enci(7, 5, 2);
        imem[3] = enc(13, 1, 5, 0);
        auto_ack = 1'b0;
        force_ack = 1'b0;
        start();
        for (int i = 0; i < 50 && !trap_valid; i++) @(negedge clk);
        chk("R9 raised", {15'd0, trap_valid}, 16'd1);
        chk("R9 data", trap_data, 16'h0033);
        chk("R9 code", {8'd0, trap_code}, 16'h005A);
        for (int i = 0; i < 5; i++) @(negedge clk);
        chk("R9 stalled", {15'd0, trap_valid}, 16'd1);
        chk("R9 pc held", imem_addr, 16'd1);
        chk("R9 no progress", dmem[2], 16'hDEAD);
        force_ack = 1'b1;
        @(negedge clk);
        force_ack = 1'b0;
        for (int i = 0; i < 50 && !halted; i++) @(negedge clk);
        chk("R9 resumed", dmem[2], 16'h0033);
        auto_ack = 1'b1;

        // R9 acknowledge already high when trap rises
        auto_ack = 1'b0;
        force_ack = 1'b1;
        run("R9 early ack done");
        chk("R9 one trap cycle", trap_cycles[15:0], 16'd1);
        chk("R9 early ack result", dmem[2], 16'h0033);
        force_ack = 1'b0;
        auto_ack = 1'b1;

        // R1 reset again mid-halt restarts at 0
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 re-reset", {imem_addr[14:0], halted}, 16'd0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule